// File: doc/BRIEF.md
# Supervisor Operating-Mode Controller

This block sequences the operating modes of a system-supervisor chip and owns the active-low reset line to the host processor. It starts the host through a stretched reset pulse. It then waits for the external window watchdog to report whether the host initialised it. Depending on the result, it moves the host into a running mode, into a second-chance restart, or into a low-power fail-safe state. In the fail-safe state the reset line is held low until a wake-up arrives and the internal oscillator is healthy.

While running, the host can ask for Flash, Standby or Sleep mode. A watchdog miss or an unacknowledged interrupt sends the controller back through a fresh start-up. Wake requests from CAN, LIN or a local pin end Standby and Sleep. A 3-bit reset-source code records why the most recent start-up or restart happened, so that host software can choose its initialisation path. All timings are counted in system-clock cycles, and the reset output comes straight from a flop.

Top module: `supv_mode_ctrl`

## Requirements
- R1: On power-on (rstPorN low), mode is Start-up (code 0) and rstSrc is power-on (code 0). After rstPorN rises, rstN stays low for LONG_CYC cycles, counting the cycle of release.
- R2: A start-up caused by a watchdog miss, an interrupt timeout or a wake holds rstN low for SHORT_CYC cycles when cfgShortRst is 1, and for LONG_CYC cycles when it is 0.
- R3: rstN rises only while mode is Start-up or Restart. After it rises, the mode stays unchanged until wdInitOk or wdInitFail arrives.
- R4: A wdInitOk in Start-up enters Flash (code 4) if hostSelFlash is 1, and Normal (code 3) otherwise.
- R5: A wdInitFail in Start-up enters Restart (code 1) and sets rstSrc to restart (code 4). rstN is then held low for LONG_CYC cycles, whatever cfgShortRst is.
- R6: A wdInitOk in Restart, with regGood high, always enters Normal, even when hostSelFlash is 1.
- R7: In Restart, after rstN has risen, either a wdInitFail or regGood low enters Fail-safe (code 2).
- R8: severeFault in any mode enters Fail-safe on the next clock, with rstN low. It takes priority over every other input.
- R9: Fail-safe is left only when a wake (wakeCan, wakeLin or wakePin) is seen while oscOk is high. Mode then stays Fail-safe for FS_DLY_CYC more cycles, enters Start-up with rstSrc fail-safe exit (code 5), and holds rstN low for LONG_CYC cycles.
- R10: In Normal, wdMissed enters Start-up with rstSrc watchdog (code 1). intTimeout enters Start-up with rstSrc interrupt timeout (code 2). wdMissed wins when both arrive together. In Flash, wdMissed also resets.
- R11: A wake in Standby (code 5) or Sleep (code 6) enters Start-up with rstSrc wake (code 3). rstN is high in Standby and low in Sleep.
- R12: In Normal or Flash, hostReqValid moves to the mode given by hostReqMode (0 Normal, 1 Flash, 2 Standby, 3 Sleep). A reset event outranks it, and it is ignored in all other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstPorN | input | 1 | Power-on reset, active low, asynchronous |
| cfgShortRst | input | 1 | Select the short reset-lengthening time |
| hostSelFlash | input | 1 | Start-up target: 1 Flash, 0 Normal |
| wdInitOk | input | 1 | Watchdog initialised successfully |
| wdInitFail | input | 1 | Watchdog initialisation failed |
| wdMissed | input | 1 | Watchdog service missed |
| intTimeout | input | 1 | Host did not acknowledge an interrupt in time |
| wakeCan | input | 1 | Wake request from the CAN transceiver |
| wakeLin | input | 1 | Wake request from the LIN transceiver |
| wakePin | input | 1 | Wake request from the local wake pin |
| regGood | input | 1 | Main regulator output is good |
| oscOk | input | 1 | On-chip oscillator is running correctly |
| severeFault | input | 1 | Severe fault detected |
| hostReqValid | input | 1 | Host mode-change request strobe |
| hostReqMode | input | 2 | Requested mode: 0 Normal, 1 Flash, 2 Standby, 3 Sleep |
| rstN | output | 1 | Host reset, active low, registered |
| mode | output | 3 | Current operating mode code |
| rstSrc | output | 3 | Reset-source code for the host to read |

## Verification
The hardest state to reach is the exit from Fail-safe. It needs a failed watchdog initialisation, then a second failure or a regulator drop in Restart, and then a wake that first arrives while the oscillator flag is low and must be ignored. The stimulus follows that chain from power-on. It probes the mode one cycle before and one cycle after the discharge delay ends, and then measures the reset pulse that follows. Priority between simultaneous events is covered by table rows that raise several inputs in the same cycle from Normal mode.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [2:0] {
    MD_START    = 3'd0,
    MD_RESTART  = 3'd1,
    MD_FAILSAFE = 3'd2,
    MD_NORMAL   = 3'd3,
    MD_FLASH    = 3'd4,
    MD_STANDBY  = 3'd5,
    MD_SLEEP    = 3'd6
  } modeT;

  typedef enum logic [1:0] {
    PH_LEN    = 2'd0,
    PH_WDWAIT = 2'd1,
    PH_IDLE   = 2'd2,
    PH_DISCH  = 2'd3
  } phaseT;

  typedef enum logic [2:0] {
    SRC_POR     = 3'd0,
    SRC_WDOG    = 3'd1,
    SRC_INTTO   = 3'd2,
    SRC_WAKE    = 3'd3,
    SRC_RESTART = 3'd4,
    SRC_FSEXIT  = 3'd5
  } srcT;

  typedef enum logic [1:0] {
    CNT_SHORT = 2'd0,
    CNT_LONG  = 2'd1,
    CNT_FSDLY = 2'd2
  } cntSelT;

  typedef struct packed {
    logic   loadCnt;
    cntSelT cntSel;
    logic   rstLow;
    logic   rstHigh;
    logic   srcWr;
    srcT    srcVal;
  } strobeT;

endpackage

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic       clk,
  input  logic       rstPorN,
  input  logic       cfgShortRst,
  input  logic       hostSelFlash,
  input  logic       wdInitOk,
  input  logic       wdInitFail,
  input  logic       wdMissed,
  input  logic       intTimeout,
  input  logic       wakeAny,
  input  logic       regGood,
  input  logic       oscOk,
  input  logic       severeFault,
  input  logic       hostReqValid,
  input  logic [1:0] hostReqMode,
  input  logic       cntDone,
  output modeT       mode,
  output strobeT     stb
);

  phaseT phase;
  modeT  nextMode;
  phaseT nextPhase;

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      mode  <= MD_START;
      phase <= PH_LEN;
    end else begin
      mode  <= nextMode;
      phase <= nextPhase;
    end
  end

  always_comb begin
    nextMode  = mode;
    nextPhase = phase;
    stb       = '0;
    stb.cntSel = CNT_LONG;
    stb.srcVal = SRC_POR;

    if (severeFault) begin
      nextMode   = MD_FAILSAFE;
      nextPhase  = PH_IDLE;
      stb.rstLow = 1'b1;
    end else begin
      unique case (mode)
        MD_START: begin
          if (phase == PH_LEN) begin
            if (cntDone) begin
              nextPhase   = PH_WDWAIT;
              stb.rstHigh = 1'b1;
            end
          end else if (wdInitFail) begin
            nextMode    = MD_RESTART;
            nextPhase   = PH_LEN;
            stb.loadCnt = 1'b1;
            stb.cntSel  = CNT_LONG;
            stb.rstLow  = 1'b1;
            stb.srcWr   = 1'b1;
            stb.srcVal  = SRC_RESTART;
          end else if (wdInitOk) begin
            nextMode  = hostSelFlash ? MD_FLASH : MD_NORMAL;
            nextPhase = PH_IDLE;
          end
        end

        MD_RESTART: begin
          if (phase == PH_LEN) begin
            if (cntDone) begin
              nextPhase   = PH_WDWAIT;
              stb.rstHigh = 1'b1;
            end
          end else if (!regGood || wdInitFail) begin
            nextMode   = MD_FAILSAFE;
            nextPhase  = PH_IDLE;
            stb.rstLow = 1'b1;
          end else if (wdInitOk) begin
            nextMode  = MD_NORMAL;
            nextPhase = PH_IDLE;
          end
        end

        MD_FAILSAFE: begin
          if (phase == PH_DISCH) begin
            if (cntDone) begin
              nextMode    = MD_START;
              nextPhase   = PH_LEN;
              stb.loadCnt = 1'b1;
              stb.cntSel  = CNT_LONG;
              stb.rstLow  = 1'b1;
              stb.srcWr   = 1'b1;
              stb.srcVal  = SRC_FSEXIT;
            end
          end else if (wakeAny && oscOk) begin
            nextPhase   = PH_DISCH;
            stb.loadCnt = 1'b1;
            stb.cntSel  = CNT_FSDLY;
          end
        end

        MD_NORMAL, MD_FLASH: begin
          if (wdMissed || (intTimeout && mode == MD_NORMAL)) begin
            nextMode    = MD_START;
            nextPhase   = PH_LEN;
            stb.loadCnt = 1'b1;
            stb.cntSel  = cfgShortRst ? CNT_SHORT : CNT_LONG;
            stb.rstLow  = 1'b1;
            stb.srcWr   = 1'b1;
            stb.srcVal  = wdMissed ? SRC_WDOG : SRC_INTTO;
          end else if (hostReqValid) begin
            nextPhase = PH_IDLE;
            unique case (hostReqMode)
              2'd0: nextMode = MD_NORMAL;
              2'd1: nextMode = MD_FLASH;
              2'd2: nextMode = MD_STANDBY;
              default: begin
                nextMode   = MD_SLEEP;
                stb.rstLow = 1'b1;
              end
            endcase
          end
        end

        MD_STANDBY, MD_SLEEP: begin
          if (wakeAny) begin
            nextMode    = MD_START;
            nextPhase   = PH_LEN;
            stb.loadCnt = 1'b1;
            stb.cntSel  = cfgShortRst ? CNT_SHORT : CNT_LONG;
            stb.rstLow  = 1'b1;
            stb.srcWr   = 1'b1;
            stb.srcVal  = SRC_WAKE;
          end
        end

        default: begin
          nextMode   = MD_FAILSAFE;
          nextPhase  = PH_IDLE;
          stb.rstLow = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/supv_dpath.sv
module supv_dpath
  import supv_pkg::*;
#(
  parameter int SHORT_CYC  = 8,
  parameter int LONG_CYC   = 32,
  parameter int FS_DLY_CYC = 16,
  parameter int CNT_W      = 6
) (
  input  logic   clk,
  input  logic   rstPorN,
  input  strobeT stb,
  output logic   cntDone,
  output logic   rstN,
  output srcT    rstSrc
);

  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] FS_LD    = CNT_W'(FS_DLY_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (stb.cntSel)
      CNT_SHORT: loadVal = SHORT_LD;
      CNT_FSDLY: loadVal = FS_LD;
      default:   loadVal = LONG_LD;
    endcase
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      cnt <= LONG_LD;
    end else if (stb.loadCnt) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntDone = (cnt == '0);

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      rstN <= 1'b0;
    end else if (stb.rstLow) begin
      rstN <= 1'b0;
    end else if (stb.rstHigh) begin
      rstN <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      rstSrc <= SRC_POR;
    end else if (stb.srcWr) begin
      rstSrc <= stb.srcVal;
    end
  end

endmodule

// File: rtl/supv_mode_ctrl.sv
module supv_mode_ctrl
  import supv_pkg::*;
#(
  parameter int SHORT_CYC  = 8,
  parameter int LONG_CYC   = 32,
  parameter int FS_DLY_CYC = 16
) (
  input  logic       clk,
  input  logic       rstPorN,
  input  logic       cfgShortRst,
  input  logic       hostSelFlash,
  input  logic       wdInitOk,
  input  logic       wdInitFail,
  input  logic       wdMissed,
  input  logic       intTimeout,
  input  logic       wakeCan,
  input  logic       wakeLin,
  input  logic       wakePin,
  input  logic       regGood,
  input  logic       oscOk,
  input  logic       severeFault,
  input  logic       hostReqValid,
  input  logic [1:0] hostReqMode,
  output logic       rstN,
  output logic [2:0] mode,
  output logic [2:0] rstSrc
);

  localparam int MAX_CYC = (LONG_CYC > FS_DLY_CYC) ?
                           ((LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC) :
                           ((FS_DLY_CYC > SHORT_CYC) ? FS_DLY_CYC : SHORT_CYC);
  localparam int CNT_W = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  strobeT stb;
  modeT   modeInt;
  srcT    srcInt;
  logic   cntDone;
  logic   wakeAny;

  assign wakeAny = wakeCan | wakeLin | wakePin;

  supv_ctrl u_ctrl (
    .clk          (clk),
    .rstPorN      (rstPorN),
    .cfgShortRst  (cfgShortRst),
    .hostSelFlash (hostSelFlash),
    .wdInitOk     (wdInitOk),
    .wdInitFail   (wdInitFail),
    .wdMissed     (wdMissed),
    .intTimeout   (intTimeout),
    .wakeAny      (wakeAny),
    .regGood      (regGood),
    .oscOk        (oscOk),
    .severeFault  (severeFault),
    .hostReqValid (hostReqValid),
    .hostReqMode  (hostReqMode),
    .cntDone      (cntDone),
    .mode         (modeInt),
    .stb          (stb)
  );

  supv_dpath #(
    .SHORT_CYC  (SHORT_CYC),
    .LONG_CYC   (LONG_CYC),
    .FS_DLY_CYC (FS_DLY_CYC),
    .CNT_W      (CNT_W)
  ) u_dpath (
    .clk     (clk),
    .rstPorN (rstPorN),
    .stb     (stb),
    .cntDone (cntDone),
    .rstN    (rstN),
    .rstSrc  (srcInt)
  );

  assign mode   = modeInt;
  assign rstSrc = srcInt;

endmodule

// File: rtl/supv_chk.sv
module supv_chk
  import supv_pkg::*;
(
  input logic       clk,
  input logic       rstPorN,
  input logic       severeFault,
  input logic       rstN,
  input logic [2:0] mode
);

  AST_FS_HOLDS_RST: assert property (@(posedge clk) disable iff (!rstPorN)
    (mode == MD_FAILSAFE) |-> !rstN); // R8

  AST_FAULT_TO_FS: assert property (@(posedge clk) disable iff (!rstPorN)
    severeFault |=> (mode == MD_FAILSAFE)); // R8

  AST_RUN_RST_HIGH: assert property (@(posedge clk) disable iff (!rstPorN)
    (mode == MD_NORMAL || mode == MD_FLASH || mode == MD_STANDBY) |-> rstN); // R12

  AST_SLEEP_RST_LOW: assert property (@(posedge clk) disable iff (!rstPorN)
    (mode == MD_SLEEP) |-> !rstN); // R11

  AST_RELEASE_IN_STARTUP: assert property (@(posedge clk) disable iff (!rstPorN)
    $rose(rstN) |-> (mode == MD_START || mode == MD_RESTART)); // R3

  AST_RESTART_FROM_START: assert property (@(posedge clk) disable iff (!rstPorN)
    (mode == MD_RESTART && $past(mode) != MD_RESTART) |-> ($past(mode) == MD_START)); // R5

  AST_FS_EXIT_START: assert property (@(posedge clk) disable iff (!rstPorN)
    ($past(mode) == MD_FAILSAFE && mode != MD_FAILSAFE) |-> (mode == MD_START)); // R9

  AST_RESTART_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rstPorN)
    ($past(mode) == MD_RESTART && mode == MD_FLASH) |-> 1'b0); // R6

endmodule

bind supv_mode_ctrl supv_chk u_chk (
  .clk         (clk),
  .rstPorN     (rstPorN),
  .severeFault (severeFault),
  .rstN        (rstN),
  .mode        (mode)
);

// File: tb/sim_supv_mode_ctrl.sv
module sim_supv_mode_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int SHORT_CYC  = 8;
  localparam int LONG_CYC   = 32;
  localparam int FS_DLY_CYC = 16;

  localparam int M_START = 0, M_RESTART = 1, M_FS = 2, M_NORMAL = 3;
  localparam int M_FLASH = 4, M_STANDBY = 5, M_SLEEP = 6;
  localparam int S_POR = 0, S_WDOG = 1, S_INTTO = 2, S_WAKE = 3;
  localparam int S_RESTART = 4, S_FSEXIT = 5, S_SKIP = 7;

  // fields: severe, wdMiss, intTo, reqV, reqMode[1:0], expMode[2:0], expRstN, expSrc[2:0]
  localparam int NVEC = 8;
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 3'd2, 1'b0, 3'd7},  // R8 fault beats reset
    {1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 3'd0, 1'b0, 3'd1},  // R10 wd beats int, R12
    {1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 3'd2},  // R10 int timeout
    {1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 3'd5, 1'b1, 3'd0},  // R12 standby
    {1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 3'd6, 1'b0, 3'd0},  // R12 sleep
    {1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 3'd4, 1'b1, 3'd0},  // R12 flash
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 1'b1, 3'd0},  // R12 idle
    {1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 3'd0, 1'b0, 3'd2}   // R12 reset beats request
  };

  logic clk = 1'b0;
  logic rstPorN, cfgShortRst, hostSelFlash, wdInitOk, wdInitFail, wdMissed;
  logic intTimeout, wakeCan, wakeLin, wakePin, regGood, oscOk, severeFault;
  logic hostReqValid;
  logic [1:0] hostReqMode;
  logic rstN;
  logic [2:0] mode, rstSrc;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supv_mode_ctrl #(
    .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .FS_DLY_CYC(FS_DLY_CYC)
  ) u0 (
    .clk(clk), .rstPorN(rstPorN), .cfgShortRst(cfgShortRst),
    .hostSelFlash(hostSelFlash), .wdInitOk(wdInitOk), .wdInitFail(wdInitFail),
    .wdMissed(wdMissed), .intTimeout(intTimeout), .wakeCan(wakeCan),
    .wakeLin(wakeLin), .wakePin(wakePin), .regGood(regGood), .oscOk(oscOk),
    .severeFault(severeFault), .hostReqValid(hostReqValid),
    .hostReqMode(hostReqMode), .rstN(rstN), .mode(mode), .rstSrc(rstSrc)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clearIn();
    wdInitOk = 0; wdInitFail = 0; wdMissed = 0; intTimeout = 0;
    wakeCan = 0; wakeLin = 0; wakePin = 0; severeFault = 0;
    hostReqValid = 0; hostReqMode = 2'd0;
  endtask

  task automatic countLow(output int n);
    n = 0;
    while (!rstN && n < 1000) begin
      n++;
      step();
    end
  endtask

  task automatic powerOn();
    clearIn();
    rstPorN = 0;
    step(); step();
    rstPorN = 1;
  endtask

  task automatic goNormal();
    int n;
    powerOn();
    countLow(n);
    hostSelFlash = 0; wdInitOk = 1; step(); wdInitOk = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int n;
    rstPorN = 0; cfgShortRst = 0; hostSelFlash = 0; regGood = 1; oscOk = 1;
    clearIn();
    @(negedge clk);

    // R1: power-on state and long pulse
    powerOn();
    chkEq("R1", "mode after power-on", mode, M_START);
    chkEq("R1", "rstSrc after power-on", rstSrc, S_POR);
    chkEq("R1", "rstN after power-on", rstN, 0);
    countLow(n);
    chkEq("R1", "power-on low cycles", n, LONG_CYC);

    // R3: wait for watchdog result
    step(); step(); step();
    chkEq("R3", "mode while waiting", mode, M_START);
    chkEq("R3", "rstN while waiting", rstN, 1);

    // R4: Flash target
    hostSelFlash = 1; wdInitOk = 1; step(); wdInitOk = 0;
    chkEq("R4", "flash selected", mode, M_FLASH);
    hostSelFlash = 0;

    // Table walk from Normal mode
    for (int i = 0; i < NVEC; i++) begin
      goNormal();
      chkEq("R4", "normal selected", mode, M_NORMAL);
      severeFault  = VEC[i][12];
      wdMissed     = VEC[i][11];
      intTimeout   = VEC[i][10];
      hostReqValid = VEC[i][9];
      hostReqMode  = VEC[i][8:7];
      step();
      clearIn();
      chkEq("R12", $sformatf("vector %0d mode", i), mode, int'(VEC[i][6:4]));
      chkEq("R12", $sformatf("vector %0d rstN", i), rstN, int'(VEC[i][3]));
      if (VEC[i][2:0] != 3'd7)
        chkEq("R10", $sformatf("vector %0d rstSrc", i), rstSrc, int'(VEC[i][2:0]));
    end

    // R2 / R10: short then long lengthening
    goNormal();
    cfgShortRst = 1; wdMissed = 1; step(); wdMissed = 0;
    chkEq("R10", "watchdog source", rstSrc, S_WDOG);
    countLow(n);
    chkEq("R2", "short pulse", n, SHORT_CYC);
    wdInitOk = 1; step(); wdInitOk = 0;
    cfgShortRst = 0; intTimeout = 1; step(); intTimeout = 0;
    chkEq("R10", "int timeout source", rstSrc, S_INTTO);
    countLow(n);
    chkEq("R2", "long pulse", n, LONG_CYC);
    wdInitOk = 1; hostSelFlash = 1; step(); wdInitOk = 0; hostSelFlash = 0;
    chkEq("R4", "flash after reset", mode, M_FLASH);
    wdMissed = 1; step(); wdMissed = 0;
    chkEq("R10", "flash watchdog reset", mode, M_START);

    // R5 / R6: restart forces long and leads only to Normal
    powerOn(); countLow(n);
    cfgShortRst = 1; wdInitFail = 1; step(); wdInitFail = 0;
    chkEq("R5", "restart mode", mode, M_RESTART);
    chkEq("R5", "restart source", rstSrc, S_RESTART);
    countLow(n);
    chkEq("R5", "restart pulse", n, LONG_CYC);
    cfgShortRst = 0;
    hostSelFlash = 1; wdInitOk = 1; step(); wdInitOk = 0; hostSelFlash = 0;
    chkEq("R6", "restart to normal", mode, M_NORMAL);

    // R7: regulator not good in Restart
    powerOn(); countLow(n);
    wdInitFail = 1; step(); wdInitFail = 0;
    countLow(n);
    regGood = 0; step(); regGood = 1;
    chkEq("R7", "regulator fail", mode, M_FS);

    // R7: second watchdog failure
    powerOn(); countLow(n);
    wdInitFail = 1; step(); countLow(n);
    step(); wdInitFail = 0;
    chkEq("R7", "second init fail", mode, M_FS);
    chkEq("R8", "fail-safe rstN", rstN, 0);

    // R9: wake ignored while oscillator bad
    oscOk = 0; wakeCan = 1; step(); wakeCan = 0;
    repeat (FS_DLY_CYC + 2) step();
    chkEq("R9", "wake without osc", mode, M_FS);
    chkEq("R9", "rstN held", rstN, 0);
    oscOk = 1; wakeLin = 1; step(); wakeLin = 0;
    repeat (FS_DLY_CYC - 1) step();
    chkEq("R9", "still discharging", mode, M_FS);
    step();
    chkEq("R9", "exit to start-up", mode, M_START);
    chkEq("R9", "fail-safe exit source", rstSrc, S_FSEXIT);
    countLow(n);
    chkEq("R9", "exit pulse", n, LONG_CYC);

    // R8: fault while waiting for watchdog
    severeFault = 1; step(); severeFault = 0;
    chkEq("R8", "fault in start-up", mode, M_FS);

    // R11: wake from Standby and Sleep
    goNormal();
    hostReqValid = 1; hostReqMode = 2'd2; step(); clearIn();
    hostReqValid = 1; hostReqMode = 2'd0; step(); clearIn();
    chkEq("R12", "request ignored in standby", mode, M_STANDBY);
    chkEq("R11", "standby rstN", rstN, 1);
    wakePin = 1; step(); wakePin = 0;
    chkEq("R11", "wake from standby", mode, M_START);
    chkEq("R11", "wake source", rstSrc, S_WAKE);
    countLow(n);
    chkEq("R11", "wake pulse", n, LONG_CYC);
    wdInitOk = 1; step(); wdInitOk = 0;
    hostReqValid = 1; hostReqMode = 2'd3; step(); clearIn();
    chkEq("R11", "sleep rstN", rstN, 0);
    wakeCan = 1; step(); wakeCan = 0;
    chkEq("R11", "wake from sleep", mode, M_START);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule